// File: doc/BRIEF.md
# Power-On Sequencer with One-Shot Configuration Capture

This block brings the digital core of a metering device out of power-up in a fixed order. An asynchronous supply-good indication from the analog section holds the core in reset while it is low. When it rises, the block passes it through a short synchronizer. It then waits a fixed number of oscillator clock periods so the clock can settle, and releases the core reset.

One cycle after the reset release, the block samples the external strap pins into holding registers. The straps are a gain code, a pulse-frequency code and a high-pass-filter enable. In that same edge it raises the measurement enable.

The captured straps drive the rest of the core for as long as the supply stays good. Later strap movement is ignored. Any loss of supply-good clears everything at once, and the full sequence repeats on the next rise.

Top module: `por_cfg_latch`

## Requirements
- R1: While `pwr_good_async` is low, `core_rst_n` and `meas_en` are 0 and `gain_cfg`, `freq_cfg` and `hpf_cfg` are all 0, without waiting for a clock edge.
- R2: After `pwr_good_async` rises between two edges, `core_rst_n` goes to 1 exactly at rising edge number SYNC_STAGES + 1 + SETTLE_CYCLES counted from that point, and not earlier.
- R3: `meas_en` goes to 1 exactly one rising edge after `core_rst_n` goes to 1, and is never 1 while `core_rst_n` is 0.
- R4: The values of `gain_pins`, `freq_pins` and `hpf_pin` present at the edge on which `meas_en` rises are the values shown on `gain_cfg`, `freq_cfg` and `hpf_cfg` from then on, bit for bit. Pin values before that edge have no effect.
- R5: While `meas_en` stays 1, changes on the strap pins have no effect on `gain_cfg`, `freq_cfg` and `hpf_cfg`.
- R6: A fall of `pwr_good_async` in any phase (synchronizing, settling, capture or running) returns all outputs to their R1 values immediately. The next rise restarts the complete R2 delay.
- R7: Every strap combination (2-bit gain, 3-bit frequency, 1-bit filter enable: 64 cases) is captured correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| pwr_good_async | input | 1 | Asynchronous supply-good from the analog section; low resets the block |
| gain_pins | input | GAIN_W | Gain strap pins |
| freq_pins | input | FREQ_W | Pulse-frequency strap pins |
| hpf_pin | input | 1 | High-pass-filter enable strap |
| core_rst_n | output | 1 | Active-low reset to the digital core |
| meas_en | output | 1 | Measurement run enable |
| gain_cfg | output | GAIN_W | Captured gain code |
| freq_cfg | output | FREQ_W | Captured frequency code |
| hpf_cfg | output | 1 | Captured high-pass-filter enable |

## Verification
The bench builds the block with SETTLE_CYCLES = 4 and SYNC_STAGES = 2, so one power-up takes only eight edges. That makes it cheap to power-cycle once for each of the 64 strap combinations and to check every edge of every release.

The short sequence also lets the bench remove supply-good at each edge offset from 1 to 10. That covers every phase, including the single capture cycle and the first running cycles. After each such drop, the bench checks the full restart delay.

In each run the strap pins hold the inverse value until the capture cycle and flip again right after it. This shows that only the capture-edge value is kept.

// File: rtl/por_pkg.sv
package por_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_WAIT  = 2'd1,
    ST_LATCH = 2'd2,
    ST_RUN   = 2'd3
  } por_state_t;

  // True on the last tick of a settle window of n clock periods.
  function automatic logic settle_last(input int unsigned cnt, input int unsigned n);
    return cnt == (n - 1);
  endfunction

  // Edge index (counted from supply-good rising) at which the core reset releases.
  function automatic int unsigned release_edge(input int unsigned stages, input int unsigned settle);
    return stages + 1 + settle;
  endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge async_in) begin
        if (!async_in) q[i] <= 1'b0;
        else           q[i] <= 1'b1;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge async_in) begin
        if (!async_in) q[i] <= 1'b0;
        else           q[i] <= q[i-1];
      end
    end
  end

  assign sync_out = q[STAGES-1];
endmodule

// File: rtl/por_seq.sv
module por_seq
  import por_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 8,
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       pwr_good_async,
  input  logic       sync_good,
  output por_state_t state,
  output logic       latch_pulse,
  output logic       wait_done
);
  por_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign wait_done = (state_q == ST_WAIT) && settle_last(32'(cnt_q), SETTLE_CYCLES);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RESET: begin
        cnt_d = '0;
        if (sync_good) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (wait_done) state_d = ST_LATCH;
        else           cnt_d   = cnt_q + CNT_W'(1);
      end
      ST_LATCH: state_d = ST_RUN;
      ST_RUN:   state_d = ST_RUN;
      default:  state_d = ST_RESET;
    endcase
    if (!sync_good) begin
      state_d = ST_RESET;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge pwr_good_async) begin
    if (!pwr_good_async) begin
      state_q <= ST_RESET;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state       = state_q;
  assign latch_pulse = (state_q == ST_LATCH);
endmodule

// File: rtl/por_cfg_reg.sv
module por_cfg_reg #(
  parameter int unsigned GAIN_W = 2,
  parameter int unsigned FREQ_W = 3
) (
  input  logic              clk,
  input  logic              pwr_good_async,
  input  logic              capture,
  input  logic [GAIN_W-1:0] gain_pins,
  input  logic [FREQ_W-1:0] freq_pins,
  input  logic              hpf_pin,
  output logic [GAIN_W-1:0] gain_cfg,
  output logic [FREQ_W-1:0] freq_cfg,
  output logic              hpf_cfg
);
  always_ff @(posedge clk or negedge pwr_good_async) begin
    if (!pwr_good_async) begin
      gain_cfg <= '0;
      freq_cfg <= '0;
      hpf_cfg  <= 1'b0;
    end else if (capture) begin
      gain_cfg <= gain_pins;
      freq_cfg <= freq_pins;
      hpf_cfg  <= hpf_pin;
    end
  end
endmodule

// File: rtl/por_cfg_latch.sv
module por_cfg_latch
  import por_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 8,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned GAIN_W        = 2,
  parameter int unsigned FREQ_W        = 3
) (
  input  logic              clk,
  input  logic              pwr_good_async,
  input  logic [GAIN_W-1:0] gain_pins,
  input  logic [FREQ_W-1:0] freq_pins,
  input  logic              hpf_pin,
  output logic              core_rst_n,
  output logic              meas_en,
  output logic [GAIN_W-1:0] gain_cfg,
  output logic [FREQ_W-1:0] freq_cfg,
  output logic              hpf_cfg
);
  logic       sync_good;
  por_state_t state;
  logic       latch_pulse;
  logic       wait_done;

  por_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .async_in (pwr_good_async),
    .sync_out (sync_good)
  );

  por_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk            (clk),
    .pwr_good_async (pwr_good_async),
    .sync_good      (sync_good),
    .state          (state),
    .latch_pulse    (latch_pulse),
    .wait_done      (wait_done)
  );

  por_cfg_reg #(.GAIN_W(GAIN_W), .FREQ_W(FREQ_W)) u_cfg (
    .clk            (clk),
    .pwr_good_async (pwr_good_async),
    .capture        (latch_pulse),
    .gain_pins      (gain_pins),
    .freq_pins      (freq_pins),
    .hpf_pin        (hpf_pin),
    .gain_cfg       (gain_cfg),
    .freq_cfg       (freq_cfg),
    .hpf_cfg        (hpf_cfg)
  );

  assign core_rst_n = (state == ST_LATCH) || (state == ST_RUN);
  assign meas_en    = (state == ST_RUN);
endmodule

// File: rtl/por_cfg_latch_chk.sv
module por_cfg_latch_chk #(
  parameter int unsigned SETTLE_CYCLES = 8,
  parameter int unsigned GAIN_W        = 2,
  parameter int unsigned FREQ_W        = 3,
  localparam int unsigned HC_W = $clog2(SETTLE_CYCLES + 3) + 1
) (
  input logic              clk,
  input logic              pwr_good_async,
  input logic              sync_good,
  input logic              latch_pulse,
  input logic [GAIN_W-1:0] gain_pins,
  input logic [FREQ_W-1:0] freq_pins,
  input logic              hpf_pin,
  input logic              core_rst_n,
  input logic              meas_en,
  input logic [GAIN_W-1:0] gain_cfg,
  input logic [FREQ_W-1:0] freq_cfg,
  input logic              hpf_cfg
);
  // Cycles for which the synchronized supply-good has been high (saturating).
  logic [HC_W-1:0] hi_cnt;
  always_ff @(posedge clk or negedge pwr_good_async) begin
    if (!pwr_good_async)                        hi_cnt <= '0;
    else if (!sync_good)                        hi_cnt <= '0;
    else if (hi_cnt != HC_W'(SETTLE_CYCLES + 2)) hi_cnt <= hi_cnt + HC_W'(1);
  end

  a_r1_reset_outputs: assert property (@(posedge clk)
    !pwr_good_async |-> (!core_rst_n && !meas_en && gain_cfg == '0 && freq_cfg == '0 && !hpf_cfg));

  a_r2_settle_len: assert property (@(posedge clk) disable iff (!pwr_good_async)
    $rose(core_rst_n) |-> (hi_cnt == HC_W'(SETTLE_CYCLES + 1)));

  a_r3_en_follows_rst: assert property (@(posedge clk) disable iff (!pwr_good_async)
    $rose(meas_en) |-> $past(core_rst_n));

  a_r3_en_needs_rst: assert property (@(posedge clk) disable iff (!pwr_good_async)
    meas_en |-> core_rst_n);

  a_r4_capture: assert property (@(posedge clk) disable iff (!pwr_good_async)
    latch_pulse |=> (meas_en && gain_cfg == $past(gain_pins) &&
                     freq_cfg == $past(freq_pins) && hpf_cfg == $past(hpf_pin)));

  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!pwr_good_async)
    ($past(meas_en) && meas_en) |-> ($stable(gain_cfg) && $stable(freq_cfg) && $stable(hpf_cfg)));
endmodule

bind por_cfg_latch por_cfg_latch_chk #(
  .SETTLE_CYCLES (SETTLE_CYCLES),
  .GAIN_W        (GAIN_W),
  .FREQ_W        (FREQ_W)
) u_chk (
  .clk            (clk),
  .pwr_good_async (pwr_good_async),
  .sync_good      (sync_good),
  .latch_pulse    (latch_pulse),
  .gain_pins      (gain_pins),
  .freq_pins      (freq_pins),
  .hpf_pin        (hpf_pin),
  .core_rst_n     (core_rst_n),
  .meas_en        (meas_en),
  .gain_cfg       (gain_cfg),
  .freq_cfg       (freq_cfg),
  .hpf_cfg        (hpf_cfg)
);

// File: tb/test_por_cfg_latch.sv
`timescale 1ns/1ps
module test_por_cfg_latch;
  localparam int SETTLE = 4;
  localparam int STAGES = 2;
  localparam int LAT_RST = STAGES + 1 + SETTLE;  // edge where core reset releases
  localparam int LAT_EN  = LAT_RST + 1;          // edge where run enable rises

  logic       clk = 1'b0;
  logic       pwr_good_async;
  logic [1:0] gain_pins;
  logic [2:0] freq_pins;
  logic       hpf_pin;
  logic       core_rst_n, meas_en, hpf_cfg;
  logic [1:0] gain_cfg;
  logic [2:0] freq_cfg;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  por_cfg_latch #(.SETTLE_CYCLES(SETTLE), .SYNC_STAGES(STAGES), .GAIN_W(2), .FREQ_W(3)) i_por_cfg_latch (
    .clk(clk), .pwr_good_async(pwr_good_async), .gain_pins(gain_pins), .freq_pins(freq_pins),
    .hpf_pin(hpf_pin), .core_rst_n(core_rst_n), .meas_en(meas_en), .gain_cfg(gain_cfg),
    .freq_cfg(freq_cfg), .hpf_cfg(hpf_cfg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int cfg_word();
    return {26'd0, gain_cfg, freq_cfg, hpf_cfg};
  endfunction

  task automatic check_all_zero(input string req);
    chk(core_rst_n == 1'b0, {req, " core_rst_n"}, int'(core_rst_n), 0);
    chk(meas_en == 1'b0, {req, " meas_en"}, int'(meas_en), 0);
    chk(cfg_word() == 0, {req, " cfg"}, cfg_word(), 0);
  endtask

  task automatic set_pins(input int w);
    gain_pins = w[5:4];
    freq_pins = w[3:1];
    hpf_pin   = w[0];
  endtask

  task automatic power_down();
    @(negedge clk);
    pwr_good_async = 1'b0;
    #1;
    check_all_zero("R1/R6 drop");
    repeat (2) @(negedge clk);
    check_all_zero("R1 held low");
  endtask

  // Full power-up with strap value w (gain[5:4], freq[3:1], hpf[0]).
  task automatic power_up(input int w);
    @(negedge clk);
    set_pins(~w & 63);
    pwr_good_async = 1'b1;
    for (int n = 1; n <= LAT_EN; n++) begin
      @(posedge clk);
      @(negedge clk);
      chk(core_rst_n == (n >= LAT_RST), $sformatf("R2 edge %0d core_rst_n", n), int'(core_rst_n), int'(n >= LAT_RST));
      chk(meas_en == (n >= LAT_EN), $sformatf("R3 edge %0d meas_en", n), int'(meas_en), int'(n >= LAT_EN));
      if (n == LAT_RST) set_pins(w);         // value present at the capture edge
      if (n == LAT_EN)  set_pins(~w & 63);   // moves right after capture
    end
    chk(cfg_word() == w, "R4/R7 captured straps", cfg_word(), w);
    repeat (3) begin
      @(negedge clk);
      set_pins((cfg_word() + 21) & 63);
    end
    @(negedge clk);
    chk(cfg_word() == w, "R5 straps ignored in run", cfg_word(), w);
    chk(meas_en == 1'b1, "R5 still running", int'(meas_en), 1);
  endtask

  initial begin
    pwr_good_async = 1'b0;
    set_pins(0);
    repeat (3) @(negedge clk);
    check_all_zero("R1 reset state");

    // R7: every strap combination across its own power cycle
    for (int w = 0; w < 64; w++) begin
      power_up(w);
      power_down();
    end

    // R6: drop supply-good at every offset, then check a full restart
    for (int d = 1; d <= LAT_EN + 2; d++) begin
      @(negedge clk);
      set_pins(42);
      pwr_good_async = 1'b1;
      repeat (d) @(negedge clk);
      pwr_good_async = 1'b0;
      #1;
      check_all_zero($sformatf("R6 drop at edge %0d", d));
      repeat (2) @(negedge clk);
      power_up((d * 11) & 63);
      power_down();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule